// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a video raster. Software loads eight length values through a small write port, one each for the sync, back porch, active and front porch segments of a line and of a frame. It then sets a command bit to start the raster. The block outputs horizontal sync, vertical sync and data enable. It passes a pixel word from its input to its output inside the active window and holds it at the idle level outside. It also reports the pixel column and line number of the active position. Each of the four video outputs has its own polarity bit.

A per-frame event sets a status flag at the first cycle of vertical sync. The flag drives an interrupt line when its mask bit is set. Timing values written while the raster runs are held in a staging copy. They are moved into the working copy only at the frame boundary, so a frame in progress is never altered. All lengths count pixel-clock cycles horizontally and whole lines vertically.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the raster is stopped, all polarity bits read 1 (active-high), the interrupt mask and status are 0, and hsync_o, vsync_o, de_o, pix_o, x_o, y_o and irq_o are all 0.
- R2: Write addresses 0..3 hold the horizontal sync, back porch, active and front porch lengths, and addresses 4..7 hold the same four vertical lengths. Each holds its length minus one, so a value of 0 gives a segment of one pixel or one line.
- R3: Each line runs sync, back porch, active, front porch in that order. hsync_o is at its active level exactly during the sync segment.
- R4: Each frame runs vertical sync, back porch, active, front porch in lines. The line count advances after the last front-porch pixel of a line, and vsync_o is active during the vertical sync lines.
- R5: de_o is active only when both the horizontal and the vertical positions are in their active segments. x_o gives the pixel index within the horizontal active segment and y_o gives the line index within the vertical active segment. Each is 0 outside its active segment and while stopped.
- R6: Address 8 holds the polarity bits: bit 0 hsync, bit 1 vsync, bit 2 data enable, bit 3 pixel data. A 1 makes the output active-high, and a 0 inverts it. pix_o outside the active window is all zeros when bit 3 is 1 and all ones when bit 3 is 0.
- R7: Writing 1 to bit 0 of address 9 starts the raster. The outputs one cycle after the write show pixel 0 of line 0, which lies in both sync segments. Writing 0 stops it, and from the following cycle every output is at its inactive level with x_o and y_o at 0.
- R8: The status bit (irq_stat_o) sets at the first cycle of vertical sync of every frame. It is cleared by writing a 1 to bit 0 of address 11. A set in the same cycle as a clear wins.
- R9: Bit 0 of address 10 is the interrupt mask. irq_o is high exactly when both the status bit and the mask bit are 1.
- R10: Length values written while running take effect at the start of the next frame. While stopped they take effect one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | CW | Register write data |
| pix_i | input | DW | Pixel word to be presented in the active window |
| hsync_o | output | 1 | Horizontal sync, polarity per bit 0 |
| vsync_o | output | 1 | Vertical sync, polarity per bit 1 |
| de_o | output | 1 | Data enable, polarity per bit 2 |
| pix_o | output | DW | Pixel word out, polarity per bit 3 |
| x_o | output | CW | Pixel index inside the active segment |
| y_o | output | CW | Line index inside the active segment |
| irq_stat_o | output | 1 | Frame-sync status flag |
| irq_o | output | 1 | Masked frame-sync interrupt |

## Verification
A wrong horizontal phase or count appears on hsync_o, de_o or x_o within one line, at most a few dozen cycles in the test timings. A wrong vertical state or a misplaced working-copy reload only appears once per frame, on vsync_o, y_o and the status flag. For that reason the reference model runs next to the design and every output is compared in every cycle, so the first divergence is reported one clock after the faulty register update. Directed counts of sync, enable and active cycles per line and per frame tie those results to the programmed lengths, including the minimum length of one, and to a length change made in the middle of a frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Segment order inside a line or a frame; the order is behaviour.
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } rtg_phase_e;

  localparam int unsigned RTG_AW = 4;

  // Addresses 0..7: bit 2 picks the axis (0 horizontal), bits 1:0 the segment.
  localparam logic [RTG_AW-1:0] A_POL  = 4'd8;
  localparam logic [RTG_AW-1:0] A_CMD  = 4'd9;
  localparam logic [RTG_AW-1:0] A_MASK = 4'd10;
  localparam logic [RTG_AW-1:0] A_STAT = 4'd11;

  localparam int unsigned POL_HS  = 0;
  localparam int unsigned POL_VS  = 1;
  localparam int unsigned POL_DE  = 2;
  localparam int unsigned POL_PIX = 3;
endpackage

// File: rtl/rtg_axis.sv
// One raster axis: walks sync, back porch, active and front porch segments.
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 step,
  input  logic [3:0][CW-1:0]   len,
  output rtg_phase_e           phase,
  output logic [CW-1:0]        cnt,
  output logic                 last
);
  logic seg_end;

  assign seg_end = (cnt == len[phase]);
  assign last    = (phase == PH_FRONT) && seg_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (seg_end) begin
        cnt   <= '0;
        phase <= rtg_phase_e'(2'(phase + 2'd1));
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtg_regs.sv
// Write port, staging and working length copies, polarity, command and
// interrupt flag.
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [RTG_AW-1:0]         wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic                      reload,
  input  logic                      vs_start,
  output logic [1:0][3:0][CW-1:0]   shd_q,
  output logic [3:0]                pol_q,
  output logic                      run_q,
  output logic                      mask_q,
  output logic                      stat_q
);
  logic [1:0][3:0][CW-1:0] stg_q;
  logic                    clr_hit;

  assign clr_hit = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '0;
      shd_q  <= '0;
      pol_q  <= 4'hF;
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (reload) shd_q <= stg_q;
      if (wr_en) begin
        if (!wr_addr[3]) begin
          stg_q[wr_addr[2]][wr_addr[1:0]] <= wr_data;
        end else begin
          case (wr_addr)
            A_POL:   pol_q  <= wr_data[3:0];
            A_CMD:   run_q  <= wr_data[0];
            A_MASK:  mask_q <= wr_data[0];
            default: ;
          endcase
        end
      end
      if (vs_start)     stat_q <= 1'b1;
      else if (clr_hit) stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtg_out.sv
// Registered output stage: decodes segments, applies polarity.
module rtg_out
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  rtg_phase_e      hph,
  input  rtg_phase_e      vph,
  input  logic [CW-1:0]   hcnt,
  input  logic [CW-1:0]   vcnt,
  input  logic [3:0]      pol,
  input  logic [DW-1:0]   pix_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [DW-1:0]   pix_o,
  output logic [CW-1:0]   x_o,
  output logic [CW-1:0]   y_o
);
  logic          hs_a, vs_a, h_in, v_in, de_a;
  logic [DW-1:0] pix_a;

  assign hs_a  = run && (hph == PH_SYNC);
  assign vs_a  = run && (vph == PH_SYNC);
  assign h_in  = run && (hph == PH_ACT);
  assign v_in  = run && (vph == PH_ACT);
  assign de_a  = h_in && v_in;
  assign pix_a = de_a ? pix_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_o   <= '0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      hsync_o <= pol[POL_HS]  ? hs_a  : !hs_a;
      vsync_o <= pol[POL_VS]  ? vs_a  : !vs_a;
      de_o    <= pol[POL_DE]  ? de_a  : !de_a;
      pix_o   <= pol[POL_PIX] ? pix_a : ~pix_a;
      x_o     <= h_in ? hcnt : '0;
      y_o     <= v_in ? vcnt : '0;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [RTG_AW-1:0]  wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic [DW-1:0]      pix_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [DW-1:0]      pix_o,
  output logic [CW-1:0]      x_o,
  output logic [CW-1:0]      y_o,
  output logic               irq_stat_o,
  output logic               irq_o
);
  localparam int NAXIS = 2;

  logic [1:0][3:0][CW-1:0] shd_q;
  logic [3:0]              pol_q;
  logic                    run_q, mask_q, stat_q;
  rtg_phase_e              ph [NAXIS];
  logic [NAXIS-1:0][CW-1:0] cnt;
  logic [NAXIS-1:0]        lst;
  logic [NAXIS-1:0]        step_v;
  logic                    frame_end, reload, vs_start;

  // Horizontal steps every cycle; vertical steps at the end of each line.
  assign step_v    = {lst[0], 1'b1};
  assign frame_end = lst[0] && lst[1];
  assign reload    = !run_q || frame_end;
  assign vs_start  = run_q && (ph[0] == PH_SYNC) && (cnt[0] == '0)
                           && (ph[1] == PH_SYNC) && (cnt[1] == '0);

  rtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .vs_start(vs_start),
    .shd_q(shd_q), .pol_q(pol_q), .run_q(run_q), .mask_q(mask_q),
    .stat_q(stat_q)
  );

  for (genvar g = 0; g < NAXIS; g++) begin : g_axis
    rtg_axis #(.CW(CW)) u_axis (
      .clk(clk), .rst(rst), .run(run_q), .step(step_v[g]),
      .len(shd_q[g]), .phase(ph[g]), .cnt(cnt[g]), .last(lst[g])
    );
  end

  rtg_out #(.CW(CW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .run(run_q), .hph(ph[0]), .vph(ph[1]),
    .hcnt(cnt[0]), .vcnt(cnt[1]), .pol(pol_q), .pix_i(pix_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
    .x_o(x_o), .y_o(y_o)
  );

  assign irq_stat_o = stat_q;
  assign irq_o      = stat_q && mask_q;
endmodule

// File: rtl/rtg_check.sv
module rtg_check
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     run_q,
  input logic                     vs_start,
  input logic                     stat_q,
  input logic                     mask_q,
  input logic                     irq_o,
  input logic                     de_o,
  input logic [3:0]               pol_q,
  input logic [CW-1:0]            x_o,
  input logic [CW-1:0]            y_o,
  input logic                     frame_end,
  input logic [1:0][3:0][CW-1:0]  shd_q
);
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (de_o != $past(pol_q[POL_DE]))); // R7
  AST_VS_SETS_STAT: assert property (@(posedge clk) disable iff (rst)
    vs_start |=> stat_q); // R8
  AST_STAT_RISE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(run_q)); // R8
  AST_IRQ_ON_MASKED_FRAME: assert property (@(posedge clk) disable iff (rst)
    (vs_start && mask_q) |=> (irq_o || !mask_q)); // R9
  AST_COORD_RUNNING: assert property (@(posedge clk) disable iff (rst)
    ((x_o != '0) || (y_o != '0)) |-> $past(run_q)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && !frame_end) |=> $stable(shd_q)); // R10
endmodule

bind raster_timing_gen rtg_check #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .vs_start(vs_start),
  .stat_q(stat_q), .mask_q(mask_q), .irq_o(irq_o), .de_o(de_o),
  .pol_q(pol_q), .x_o(x_o), .y_o(y_o), .frame_end(frame_end),
  .shd_q(shd_q)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CW = 12;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [DW-1:0] pix_i = '0;
  logic          hsync_o, vsync_o, de_o, irq_stat_o, irq_o;
  logic [DW-1:0] pix_o;
  logic [CW-1:0] x_o, y_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  raster_timing_gen #(.CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_i(pix_i), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o), .x_o(x_o), .y_o(y_o),
    .irq_stat_o(irq_stat_o), .irq_o(irq_o)
  );

  always @(negedge clk) pix_i <= pix_i + 24'h0A1B3;

  // ---------------- behavioural reference model ----------------
  bit            m_run, m_mask, m_stat;
  bit [3:0]      m_pol;
  int            m_stg[8];
  int            m_act[8];
  int            m_x, m_y;
  bit            e_hs, e_vs, e_de, e_irq, e_stat;
  logic [DW-1:0] e_pix;
  int            e_x, e_y;

  function automatic int seg_of(int p, int s, int b, int a);
    if (p < s) return 0;
    if (p < s + b) return 1;
    if (p < s + b + a) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    int hs, hb, ha, hf, vs, vb, va, vf, hp, vp;
    bit hact, vact, hsa, vsa;
    logic [DW-1:0] d;
    if (rst) begin
      m_run = 0; m_mask = 0; m_stat = 0; m_pol = 4'hF;
      for (int i = 0; i < 8; i++) begin m_stg[i] = 0; m_act[i] = 0; end
      m_x = 0; m_y = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_pix = '0; e_x = 0; e_y = 0;
      e_irq = 0; e_stat = 0;
    end else begin
      hs = m_act[0] + 1; hb = m_act[1] + 1; ha = m_act[2] + 1; hf = m_act[3] + 1;
      vs = m_act[4] + 1; vb = m_act[5] + 1; va = m_act[6] + 1; vf = m_act[7] + 1;
      hp = seg_of(m_x, hs, hb, ha);
      vp = seg_of(m_y, vs, vb, va);
      hsa  = m_run && hp == 0;
      vsa  = m_run && vp == 0;
      hact = m_run && hp == 2;
      vact = m_run && vp == 2;
      e_hs = m_pol[0] ? hsa : !hsa;
      e_vs = m_pol[1] ? vsa : !vsa;
      e_de = m_pol[2] ? (hact && vact) : !(hact && vact);
      d = (hact && vact) ? pix_i : '0;
      e_pix = m_pol[3] ? d : ~d;
      e_x = hact ? m_x - hs - hb : 0;
      e_y = vact ? m_y - vs - vb : 0;
      if (m_run && m_x == 0 && m_y == 0) m_stat = 1;
      else if (wr_en && wr_addr == 4'd11 && wr_data[0]) m_stat = 0;
      if (!m_run) begin
        m_x = 0; m_y = 0;
        for (int i = 0; i < 8; i++) m_act[i] = m_stg[i];
      end else begin
        m_x++;
        if (m_x == hs + hb + ha + hf) begin
          m_x = 0; m_y++;
          if (m_y == vs + vb + va + vf) begin
            m_y = 0;
            for (int i = 0; i < 8; i++) m_act[i] = m_stg[i];
          end
        end
      end
      if (wr_en) begin
        if (wr_addr < 4'd8) m_stg[wr_addr] = int'(wr_data);
        else if (wr_addr == 4'd8) m_pol = wr_data[3:0];
        else if (wr_addr == 4'd9) m_run = wr_data[0];
        else if (wr_addr == 4'd10) m_mask = wr_data[0];
      end
      e_stat = m_stat;
      e_irq = m_stat && m_mask;
    end
  end

  // ---------------- every-cycle comparison ----------------
  task automatic cmp1(string req, string nm, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      cmp1("R3", "hsync_o", int'(hsync_o), int'(e_hs));
      cmp1("R4", "vsync_o", int'(vsync_o), int'(e_vs));
      cmp1("R5", "de_o", int'(de_o), int'(e_de));
      cmp1("R6", "pix_o", int'(pix_o), int'(e_pix));
      cmp1("R5", "x_o", int'(x_o), e_x);
      cmp1("R5", "y_o", int'(y_o), e_y);
      cmp1("R8", "irq_stat_o", int'(irq_stat_o), int'(e_stat));
      cmp1("R9", "irq_o", int'(irq_o), int'(e_irq));
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R7 watchdog actual=%0d cycles expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    chk("R1", "hsync after reset", int'(hsync_o), 0);
    chk("R1", "de after reset", int'(de_o), 0);
    chk("R1", "irq after reset", int'(irq_o) + int'(irq_stat_o), 0);
    repeat (5) @(negedge clk);
    chk("R1", "stopped raster coordinates", int'(x_o) + int'(y_o), 0);

    // R2 lengths (minus one): H 2/3/4/2, V 1/2/3/1
    wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 1);
    wr(4, 0); wr(5, 1); wr(6, 2); wr(7, 0);
    wr(9, 1);
    n = 0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i == 0) chk("R7", "start in both syncs", int'(hsync_o && vsync_o), 1);
      if (hsync_o) n++;
    end
    chk("R2", "hsync cycles per line", n, 2);
    n = 0;
    for (int i = 11; i < 77; i++) begin
      @(negedge clk);
      if (de_o) n++;
    end
    chk("R5", "de cycles per frame", n, 12);
    n = 0;
    for (int i = 0; i < 77; i++) begin
      @(negedge clk);
      if (i == 0) chk("R8", "status set at frame start", int'(irq_stat_o), 1);
      if (vsync_o) n++;
    end
    chk("R4", "vsync cycles per frame", n, 11);

    // R8 clear, R9 mask
    wr(11, 1);
    chk("R8", "status cleared", int'(irq_stat_o), 0);
    wr(10, 1);
    chk("R9", "irq with status 0", int'(irq_o), 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq_stat_o) break;
    end
    chk("R9", "irq when status and mask", int'(irq_o), 1);
    wr(10, 0);
    chk("R9", "irq masked off", int'(irq_o), 0);

    // R6 all active-low
    wr(8, 0);
    n = 0;
    for (int i = 0; i < 77; i++) begin
      @(negedge clk);
      if (!de_o) n++;
    end
    chk("R6", "active-low de cycles per frame", n, 12);

    // R7 stop
    wr(9, 0);
    @(negedge clk);
    chk("R7", "stopped de inactive (low polarity)", int'(de_o), 1);
    chk("R7", "stopped pix idle all ones", int'(pix_o == '1), 1);
    chk("R7", "stopped syncs inactive", int'(hsync_o && vsync_o), 1);
    wr(8, 15);

    // R10 change while running
    wr(9, 1);
    n = 0;
    for (int i = 0; i < 77; i++) begin
      @(negedge clk);
      if (de_o) n++;
      if (i == 10) begin wr_en = 1'b1; wr_addr = 4'd2; wr_data = CW'(5); end
      else if (i == 11) wr_en = 1'b0;
    end
    chk("R10", "old length kept in current frame", n, 12);
    n = 0;
    for (int i = 0; i < 91; i++) begin
      @(negedge clk);
      if (de_o) n++;
    end
    chk("R10", "new length from next frame", n, 18);

    // R2 minimum lengths
    wr(9, 0);
    for (int a = 0; a < 8; a++) wr(a, 0);
    wr(9, 1);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (de_o) n++;
    end
    chk("R2", "single-cycle segments de count", n, 1);
    repeat (40) @(negedge clk);
    wr(9, 0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule